// File: doc/BRIEF.md
# Shared-Line Rail Sequencer

This block is the digital sequencing engine for a single point-of-load power rail. Many rails share two open-drain board lines. One is an active-high enable that any participant may hold low. The other is an active-low fault line that any participant may pull low. Each open-drain pad is modelled as a pull-low request output plus the sampled level of the line. Both sampled levels pass through a two-flop synchronizer before the block uses them.

While it is held in reset, and for a short settling time afterwards, the block keeps the shared enable low, so a system cannot start until every rail is ready. When it sees the enable high, it counts a programmable turn-on delay and then switches its rail on. It expects the rail's in-range input within a programmable limit. When the enable drops, it counts a programmable turn-off delay before it switches the rail off. A local timeout pulls the shared fault line low and raises an alert. A fault line pulled low by any other rail triggers the same configured reaction: retry after a holdoff, immediate shutdown, or a stepped ramp-down.

All delays count in prescaled ticks of PRESC clock cycles. The tick divider restarts whenever a delay is loaded, so every delay has an exact length.

Top module: `rail_seq_ctrl`

## Requirements
- R1: `en_pull_o` is 1 throughout reset and for INIT_TICKS ticks after it. It goes to 0 exactly INIT_TICKS*PRESC+1 clock edges after reset is released (9 edges with defaults PRESC=4 and INIT_TICKS=2). The rail is never switched on while `en_pull_o` is 1.
- R2: Suppose the shared enable line rises and the block is idle. Then `rail_en_o` rises 4*cfg_on_dly+4 clock edges later: 2 edges of synchronizer, 1 edge to load the delay, the delay itself, and 1 edge to register the output.
- R3: Suppose the rail is on and `in_range_i` stays 0 for cfg_on_max ticks. Then `flt_pull_o` and `alert_o` go to 1. If `in_range_i` arrives in time, neither output is raised.
- R4: Suppose the shared enable line falls while the rail is on. Then `rail_en_o` falls 4*cfg_off_dly+4 clock edges later.
- R5: A low level on the shared fault line that this block did not cause triggers the configured reaction. `alert_o` and `flt_pull_o` stay 0 in that case. The block's own pull, including the two cycles of synchronizer lag after it is released, is not taken as an external fault.
- R6: `cfg_mode` values 1 and 3 select immediate shutdown. `rail_en_o` goes to 0 in the same cycle the fault is detected, which is 2 edges after the fault line falls. The block then stays latched off.
- R7: `cfg_mode` value 2 selects ramp-off. `ramp_lvl_o` starts at RAMP_STEPS (4) and falls by one per tick. The rail stays on until the level reaches 0, which is 4*RAMP_STEPS+4 edges after the fault line falls. The block then stays latched off.
- R8: `cfg_mode` value 0 selects retry. The rail goes off for HOLD_TICKS ticks, and then the turn-on delay starts again. At most cfg_retries retries are made, so a fault that persists gives cfg_retries+1 rail turn-ons. After that the block stays latched off.
- R9: A latched block keeps the rail off while the enable line stays high. The block clears `alert_o`, `flt_pull_o` and its retry count only after it has seen the enable low and then high again, or on reset. Taking the enable low alone does not clear `alert_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_line_i | input | 1 | Sampled level of the shared active-high enable line |
| flt_line_i | input | 1 | Sampled level of the shared active-low fault line |
| in_range_i | input | 1 | Rail output within tolerance |
| cfg_on_dly | input | CNT_W | Turn-on delay in ticks |
| cfg_off_dly | input | CNT_W | Turn-off delay in ticks |
| cfg_on_max | input | CNT_W | Maximum ticks from turn-on to in-range |
| cfg_mode | input | 2 | Fault reaction: 0 retry, 1 or 3 immediate, 2 ramp-off |
| cfg_retries | input | RTY_W | Maximum retry count |
| en_pull_o | output | 1 | Request to pull the shared enable line low |
| flt_pull_o | output | 1 | Request to pull the shared fault line low |
| rail_en_o | output | 1 | Rail enable |
| alert_o | output | 1 | Local fault flag |
| ramp_lvl_o | output | CNT_W | Ramp level: RAMP_STEPS when on, counts down during ramp-off |

## Verification
Turn-on and turn-off delays are swept together through the values 0 to 3, with one rising as the other falls, so that an error in either count, or a swapped count, shows up as a latency that is off by a multiple of four cycles. The in-range input is driven both promptly and never, which separates a normal start-up from a local timeout. External faults are injected in each reaction mode. The time until the rail drops tells immediate shutdown apart from ramp-off, and the alert output shows whether a fault was counted as local. Persistent faults are run with retry limits of 0, 1 and 2, and the number of turn-ons is counted to confirm the retry limit. The enable line is cycled in two steps to confirm that only a full low-then-high sequence clears a latched fault.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [3:0] {
    ST_INIT, ST_IDLE, ST_ONDLY, ST_RISE, ST_ON,
    ST_OFFDLY, ST_RAMP, ST_HOLD, ST_LATCH
  } rsc_state_e;

  typedef enum logic [1:0] {
    RX_RETRY = 2'd0,
    RX_IMM   = 2'd1,
    RX_RAMP  = 2'd2
  } rsc_react_e;

  // Mode code to reaction: unused code 3 falls back to immediate shutdown.
  function automatic rsc_react_e decode_react(input logic [1:0] code);
    case (code)
      2'd0:    return RX_RETRY;
      2'd2:    return RX_RAMP;
      default: return RX_IMM;
    endcase
  endfunction

  // A retry is still allowed while fewer than the limit have been used.
  function automatic logic may_retry(input int used, input int limit);
    return used < limit;
  endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/rsc_tick.sv
module rsc_tick #(
  parameter int PRESC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == PW'(PRESC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (clr_i || tick_o)  pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/rsc_timer.sv
module rsc_timer #(
  parameter int W       = 6,
  parameter int RST_VAL = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  assign done_o = (cnt_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_o <= W'(RST_VAL);
    else if (load_i)             cnt_o <= val_i;
    else if (tick_i && !done_o)  cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rsc_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int PRESC      = 4,
  parameter int INIT_TICKS = 2,
  parameter int HOLD_TICKS = 3,
  parameter int RAMP_STEPS = 4,
  parameter int RTY_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_line_i,
  input  logic             flt_line_i,
  input  logic             in_range_i,
  input  logic [CNT_W-1:0] cfg_on_dly,
  input  logic [CNT_W-1:0] cfg_off_dly,
  input  logic [CNT_W-1:0] cfg_on_max,
  input  logic [1:0]       cfg_mode,
  input  logic [RTY_W-1:0] cfg_retries,
  output logic             en_pull_o,
  output logic             flt_pull_o,
  output logic             rail_en_o,
  output logic             alert_o,
  output logic [CNT_W-1:0] ramp_lvl_o
);
  localparam logic [CNT_W-1:0] RAMP_FULL = CNT_W'(RAMP_STEPS);
  localparam logic [CNT_W-1:0] HOLD_VAL  = CNT_W'(HOLD_TICKS);

  // Synchronized shared lines: bit0 enable (reset low), bit1 fault (reset released)
  logic [1:0] sync_q;
  logic       en_s, flt_s;
  rsc_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({flt_line_i, en_line_i}), .q_o(sync_q)
  );
  assign en_s  = sync_q[0];
  assign flt_s = sync_q[1];

  // Delay timer with a divider that restarts on every load
  logic             t_load, tick, t_done;
  logic [CNT_W-1:0] t_val, t_cnt;
  rsc_tick #(.PRESC(PRESC)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(t_load), .tick_o(tick)
  );
  rsc_timer #(.W(CNT_W), .RST_VAL(INIT_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val),
    .tick_i(tick), .cnt_o(t_cnt), .done_o(t_done)
  );

  rsc_state_e       st_q, st_n;
  logic             rail_q, rail_n, pull_q, pull_n, alert_q, alert_n;
  logic             seen_q, seen_n, pull_d1, pull_d2;
  logic [RTY_W-1:0] tries_q, tries_n;
  rsc_react_e       react;

  // Named events for the checker
  logic active, pull_seen, loc_fault, fault_ext, fault_now, st_latch, st_ramp;

  assign react     = decode_react(cfg_mode);
  assign active    = (st_q == ST_ONDLY) || (st_q == ST_RISE) ||
                     (st_q == ST_ON)    || (st_q == ST_OFFDLY);
  assign pull_seen = pull_q | pull_d1 | pull_d2;
  assign loc_fault = (st_q == ST_RISE) && !in_range_i && t_done;
  assign fault_ext = active && !flt_s && !pull_seen;
  assign fault_now = loc_fault || fault_ext;
  assign st_latch  = (st_q == ST_LATCH);
  assign st_ramp   = (st_q == ST_RAMP);

  always_comb begin
    st_n    = st_q;
    t_load  = 1'b0;
    t_val   = '0;
    rail_n  = rail_q;
    pull_n  = pull_q;
    alert_n = alert_q;
    tries_n = tries_q;
    seen_n  = seen_q;
    case (st_q)
      ST_INIT:  if (t_done) st_n = ST_IDLE;
      ST_IDLE:  if (en_s) begin st_n = ST_ONDLY; t_load = 1'b1; t_val = cfg_on_dly; end
      ST_ONDLY: begin
        if (!en_s) st_n = ST_IDLE;
        else if (t_done) begin
          st_n = ST_RISE; rail_n = 1'b1; t_load = 1'b1; t_val = cfg_on_max;
        end
      end
      ST_RISE: begin
        if (in_range_i) st_n = ST_ON;
        else if (!en_s) begin st_n = ST_OFFDLY; t_load = 1'b1; t_val = cfg_off_dly; end
      end
      ST_ON:     if (!en_s) begin st_n = ST_OFFDLY; t_load = 1'b1; t_val = cfg_off_dly; end
      ST_OFFDLY: if (t_done) begin st_n = ST_IDLE; rail_n = 1'b0; end
      ST_RAMP:   if (t_done) begin st_n = ST_LATCH; rail_n = 1'b0; seen_n = 1'b0; end
      ST_HOLD: begin
        if (t_done) begin
          st_n = ST_ONDLY; pull_n = 1'b0; t_load = 1'b1; t_val = cfg_on_dly;
        end
      end
      ST_LATCH: begin
        if (!en_s) seen_n = 1'b1;
        else if (seen_q) begin
          st_n = ST_IDLE; pull_n = 1'b0; alert_n = 1'b0; tries_n = '0; seen_n = 1'b0;
        end
      end
      default: st_n = ST_IDLE;
    endcase

    if (fault_now) begin
      if (loc_fault) begin pull_n = 1'b1; alert_n = 1'b1; end
      case (react)
        RX_RAMP: begin st_n = ST_RAMP; t_load = 1'b1; t_val = RAMP_FULL; end
        RX_RETRY: begin
          rail_n = 1'b0;
          if (may_retry(int'(tries_q), int'(cfg_retries))) begin
            tries_n = tries_q + 1'b1; st_n = ST_HOLD; t_load = 1'b1; t_val = HOLD_VAL;
          end else begin
            st_n = ST_LATCH; seen_n = 1'b0;
          end
        end
        default: begin st_n = ST_LATCH; rail_n = 1'b0; seen_n = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_INIT;
      rail_q  <= 1'b0;
      pull_q  <= 1'b0;
      alert_q <= 1'b0;
      tries_q <= '0;
      seen_q  <= 1'b0;
      pull_d1 <= 1'b0;
      pull_d2 <= 1'b0;
    end else begin
      st_q    <= st_n;
      rail_q  <= rail_n;
      pull_q  <= pull_n;
      alert_q <= alert_n;
      tries_q <= tries_n;
      seen_q  <= seen_n;
      pull_d1 <= pull_q;
      pull_d2 <= pull_d1;
    end
  end

  assign en_pull_o  = (st_q == ST_INIT);
  assign flt_pull_o = pull_q;
  assign alert_o    = alert_q;
  assign rail_en_o  = rail_q && !(fault_now && (react == RX_IMM));
  assign ramp_lvl_o = st_ramp ? t_cnt : (rail_q ? RAMP_FULL : '0);

endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk #(
  parameter int CNT_W = 6,
  parameter int RTY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rail_en_o,
  input logic             en_pull_o,
  input logic             flt_pull_o,
  input logic             alert_o,
  input logic [CNT_W-1:0] ramp_lvl_o,
  input logic [1:0]       cfg_mode,
  input logic [RTY_W-1:0] cfg_retries,
  input logic             en_s,
  input logic             fault_now,
  input logic             fault_ext,
  input logic             st_latch,
  input logic             st_ramp,
  input logic [RTY_W-1:0] tries_q
);
  assert_no_rail_while_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en_o) |-> !en_pull_o);

  assert_rail_follows_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en_o) |-> en_s);

  assert_alert_pulls_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_o) |-> flt_pull_o);

  assert_ext_no_alert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ext && !alert_o && (fault_now == fault_ext)) |=> !alert_o);

  assert_imm_same_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_now && (cfg_mode == 2'd1 || cfg_mode == 2'd3)) |-> !rail_en_o);

  assert_ramp_descends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ramp && $past(st_ramp)) |-> (ramp_lvl_o <= $past(ramp_lvl_o)));

  assert_retry_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= cfg_retries);

  assert_latched_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_latch |-> !rail_en_o);
endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk #(.CNT_W(CNT_W), .RTY_W(RTY_W)) u_chk (.*);

// File: tb/rail_seq_ctrl_tb.sv
module rail_seq_ctrl_tb;
  localparam int CNT_W = 6, PRESC = 4, INIT_T = 2, RAMP_S = 4, RTY_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tb_en = 1'b0, tb_flt = 1'b0, ir_ok = 1'b1, ir_q = 1'b0;
  logic [CNT_W-1:0] on_dly = 1, off_dly = 1, on_max = 2;
  logic [1:0] mode = 2'd1;
  logic [RTY_W-1:0] retries = '0;
  logic en_pull, flt_pull, rail_en, alert;
  logic [CNT_W-1:0] ramp_lvl;
  logic en_line, flt_line;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign en_line  = tb_en & ~en_pull;
  assign flt_line = ~(flt_pull | tb_flt);
  always @(posedge clk) ir_q <= ir_ok & rail_en;

  rail_seq_ctrl #(.CNT_W(CNT_W), .PRESC(PRESC), .INIT_TICKS(INIT_T),
                  .HOLD_TICKS(3), .RAMP_STEPS(RAMP_S), .RTY_W(RTY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_line_i(en_line), .flt_line_i(flt_line),
    .in_range_i(ir_q), .cfg_on_dly(on_dly), .cfg_off_dly(off_dly),
    .cfg_on_max(on_max), .cfg_mode(mode), .cfg_retries(retries),
    .en_pull_o(en_pull), .flt_pull_o(flt_pull), .rail_en_o(rail_en),
    .alert_o(alert), .ramp_lvl_o(ramp_lvl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic near(input string tag, input int act, input int exp);
    chk((act >= exp - 1) && (act <= exp + 1), tag, act, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count edges until rail_en equals val; caller is at a negedge
  task automatic wait_rail(input logic val, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (rail_en !== val && n < 500);
  endtask

  task automatic cycle_enable();
    tb_en = 1'b0; cyc(12);
    tb_en = 1'b1; cyc(4);
  endtask

  initial begin
    int n, rises, worst;
    logic prev;
    logic [CNT_W-1:0] last;
    cyc(4);
    chk(en_pull === 1'b1, "R1 pull in reset", en_pull, 1);
    chk(rail_en === 1'b0, "R1 rail off in reset", rail_en, 0);
    chk(alert === 1'b0 && flt_pull === 1'b0, "R3 no fault in reset", alert, 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (en_pull !== 1'b0 && n < 100);
    near("R1 release time", n, INIT_T * PRESC + 1);

    // R2/R4 sweep: turn-on and turn-off delays in opposite directions
    for (int d = 0; d < 4; d++) begin
      on_dly = CNT_W'(d); off_dly = CNT_W'(3 - d); ir_ok = 1'b1;
      tb_en = 1'b1;
      wait_rail(1'b1, n);
      near("R2 turn-on latency", n, 4 * d + 4);
      cyc(30);
      chk(rail_en === 1'b1 && alert === 1'b0 && flt_pull === 1'b0,
          "R3 in range in time, no fault", alert, 0);
      tb_en = 1'b0;
      wait_rail(1'b0, n);
      near("R4 turn-off latency", n, 4 * (3 - d) + 4);
      cyc(10);
    end

    // R3/R6 local timeout in immediate mode, then R9 latch behaviour
    mode = 2'd1; on_dly = 0; on_max = 2; ir_ok = 1'b0;
    tb_en = 1'b1; cyc(60);
    chk(flt_pull === 1'b1, "R3 timeout pulls fault line", flt_pull, 1);
    chk(alert === 1'b1, "R3 timeout raises alert", alert, 1);
    chk(rail_en === 1'b0, "R6 rail off after local fault", rail_en, 0);
    cyc(60);
    chk(rail_en === 1'b0, "R9 latched with enable high", rail_en, 0);
    tb_en = 1'b0; ir_ok = 1'b1; cyc(12);
    chk(alert === 1'b1, "R9 enable low alone keeps alert", alert, 1);
    tb_en = 1'b1; cyc(40);
    chk(rail_en === 1'b1 && alert === 1'b0 && flt_pull === 1'b0,
        "R9 cleared by enable cycle", alert, 0);

    // R5/R7 external fault in ramp mode
    mode = 2'd2;
    tb_flt = 1'b1;
    n = 0; worst = 0; last = ramp_lvl;
    do begin
      @(posedge clk); n++; @(negedge clk);
      if (ramp_lvl > last) worst++;
      last = ramp_lvl;
    end while (rail_en !== 1'b0 && n < 500);
    near("R7 ramp-off duration", n, 4 * RAMP_S + 4);
    chk(worst == 0, "R7 ramp level never rises", worst, 0);
    chk(ramp_lvl == 0, "R7 ramp ends at zero", int'(ramp_lvl), 0);
    chk(alert === 1'b0 && flt_pull === 1'b0, "R5 external fault not local", alert, 0);
    tb_flt = 1'b0; cyc(20);
    chk(rail_en === 1'b0, "R7 latched after ramp", rail_en, 0);
    cycle_enable(); cyc(30);
    chk(rail_en === 1'b1, "R9 rail back after enable cycle", rail_en, 1);

    // R6 immediate shutdown for codes 1 and 3
    for (int m = 1; m <= 3; m += 2) begin
      mode = 2'(m);
      tb_flt = 1'b1;
      wait_rail(1'b0, n);
      near("R6 immediate drop", n, 2);
      chk(alert === 1'b0, "R5 external leaves alert low", alert, 0);
      tb_flt = 1'b0; cyc(10);
      chk(rail_en === 1'b0, "R6 stays latched", rail_en, 0);
      cycle_enable(); cyc(30);
    end

    // R8 retry limit sweep with a rail that never comes in range
    mode = 2'd0; on_dly = 1; on_max = 1;
    for (int r = 0; r < 3; r++) begin
      tb_en = 1'b0; retries = RTY_W'(r); ir_ok = 1'b0; cyc(12);
      tb_en = 1'b1;
      rises = 0; prev = rail_en;
      repeat (400) begin
        @(negedge clk);
        if (rail_en && !prev) rises++;
        prev = rail_en;
      end
      chk(rises == r + 1, "R8 turn-on count", rises, r + 1);
      chk(rail_en === 1'b0 && alert === 1'b1, "R8 latched after retries", rail_en, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule